// File: doc/BRIEF.md
# Multi-board sync pulse sequencer

This block sits on the master board of a group of acquisition boards. It drives the single SYNC/TRIG line that all boards in the group watch. Once armed, it plays out a fixed train of up to five pulses on that line:

- an optional DDS-update pulse timed in system clocks;
- an optional long ADC reset/settling pulse;
- a mandatory acquisition-start pulse;
- later, a start-trigger pulse and a stop-trigger pulse, each issued only when selected and only when the matching event arrives.

Every pulse except the DDS-update one rises and falls on a falling edge of the ADC sample clock. The ADC clock is resynchronised into the system clock domain and only its falling edges are used.

The sequence runs only while both arm and master are high. A board that is not master, or that is disarmed, keeps the line low and returns to idle. When the sequence is complete, the block parks in a done phase until arm is released, so one arming produces exactly one train. The trigger event strobes are one system clock wide and synchronous to the system clock.

Top module: `sync_pulse_seq`

## Requirements
- R1: After reset, sync_o is low, busy_o is low and phase_o reads 0 (idle).
- R2: While master_i is low, no pulse is produced whatever arm_i does, and phase_o stays 0.
- R3: When armed with sync_need_i high, the first pulse is the DDS-update pulse (phase_o = 1), exactly P1_CYC system clocks wide.
- R4: When armed with sync_need_i high, the second pulse is the ADC reset pulse (phase_o = 2), exactly P2_LEN ADC periods wide; with sync_need_i low, neither this pulse nor the DDS-update pulse appears.
- R5: The acquisition-start pulse (phase_o = 3) is always produced, is exactly ACQ_LEN ADC periods wide, and rises on an ADC falling edge; all ADC-timed pulses share that alignment.
- R6: The start-trigger pulse (phase_o = 4), TRIG_LEN ADC periods wide, appears only if start_sel_i is high and a start_ev_i strobe is accepted.
- R7: The stop-trigger pulse (phase_o = 5), TRIG_LEN ADC periods wide, appears only if stop_sel_i is high and a stop_ev_i strobe is accepted. When start_sel_i is high, a stop strobe is accepted only after the start-trigger pulse.
- R8: Pulses appear in the order 1, 2, 3, 4, 5. Every low interval between pulses lasts at least one ADC period, and the low interval before the acquisition-start pulse lasts exactly one ADC period when the reset pulse precedes it.
- R9: A trigger strobe is ignored if it arrives during an earlier pulse, or before one full ADC period of low time has followed that pulse.
- R10: When arm_i or master_i falls, sync_o is low and phase_o reads 0 after the next system clock edge.
- R11: After the last pulse, phase_o reads 7 and busy_o is low. No further pulse is produced while arm_i stays high.
- R12: phase_o reads 6 during inter-pulse gaps and while waiting for a trigger, and busy_o is high exactly when phase_o is between 1 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_clk_i | input | 1 | ADC sample clock, sampled in the system clock domain |
| master_i | input | 1 | Board is master of the group |
| arm_i | input | 1 | Run the sequence while high; falling aborts it |
| sync_need_i | input | 1 | Include the DDS-update and ADC reset pulses |
| start_sel_i | input | 1 | Acquisition starts on a trigger event |
| stop_sel_i | input | 1 | Acquisition stops on a trigger event |
| start_ev_i | input | 1 | Start trigger event strobe, one clock wide |
| stop_ev_i | input | 1 | Stop trigger event strobe, one clock wide |
| sync_o | output | 1 | SYNC/TRIG line |
| busy_o | output | 1 | Sequence in progress |
| phase_o | output | 3 | 0 idle, 1 to 5 pulse phase, 6 gap or wait, 7 done |

## Verification
The bench sweeps all eight combinations of sync-needed, start-select and stop-select. In each one it fires trigger strobes at the points where they must be ignored: during the acquisition-start pulse, in the gap just after it, and during the start-trigger pulse. It also fires a stop strobe while a start is still awaited. A design that accepted any of these would emit an extra or premature pulse, which shows up in the pulse count or in the phase order. Pulse widths are measured in system clocks against whole multiples of the ADC period, and rise times are compared modulo that period. An off-by-one in a length counter, or a pulse launched on the wrong ADC edge, shows up as a width or alignment miscompare. Separate runs abort the train in the middle of the long reset pulse and try to arm a non-master board; a design that missed either would leave the line high or emit pulses.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DDS, S_ADCRST, S_ACQ, S_TRGA, S_TRGB,
    S_GAP, S_WAIT_A, S_PEND_A, S_WAIT_B, S_PEND_B, S_DONE
  } seq_state_e;

  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_DDS  = 3'd1;
  localparam logic [2:0] PH_RST  = 3'd2;
  localparam logic [2:0] PH_ACQ  = 3'd3;
  localparam logic [2:0] PH_TRGA = 3'd4;
  localparam logic [2:0] PH_TRGB = 3'd5;
  localparam logic [2:0] PH_WAIT = 3'd6;
  localparam logic [2:0] PH_DONE = 3'd7;

  function automatic logic [2:0] phase_code(seq_state_e s);
    case (s)
      S_IDLE:   return PH_IDLE;
      S_DDS:    return PH_DDS;
      S_ADCRST: return PH_RST;
      S_ACQ:    return PH_ACQ;
      S_TRGA:   return PH_TRGA;
      S_TRGB:   return PH_TRGB;
      S_DONE:   return PH_DONE;
      default:  return PH_WAIT;
    endcase
  endfunction

endpackage

// File: rtl/adc_fall_det.sv
module adc_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adc_clk_i,
  output logic fall_o
);
  localparam int N = SYNC_STAGES + 1;

  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[N-2:0], adc_clk_i};
  end

  assign fall_o = q[N-1] & ~q[N-2];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import sync_seq_pkg::*;
#(
  parameter int P1_CYC   = 40,
  parameter int P2_LEN   = 11468800,
  parameter int ACQ_LEN  = 5,
  parameter int TRIG_LEN = 2,
  parameter int CW       = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          sync_need_i,
  input  logic          start_sel_i,
  input  logic          stop_sel_i,
  input  logic          start_ev_i,
  input  logic          stop_ev_i,
  input  logic          adc_fall_i,
  input  logic          expire_i,
  output seq_state_e    state_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          tick_o
);
  seq_state_e state_q, state_d, next_q, next_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      next_q  <= S_IDLE;
    end else begin
      state_q <= state_d;
      next_q  <= next_d;
    end
  end

  // DDS pulse counts system clocks, everything else counts ADC falls
  assign tick_o = (state_q == S_DDS) ? 1'b1 : adc_fall_i;

  always_comb begin
    state_d    = state_q;
    next_d     = next_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!run_i) begin
      state_d = S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: begin
          load_o = 1'b1;
          if (sync_need_i) begin
            state_d    = S_DDS;
            load_val_o = CW'(P1_CYC);
          end else begin
            state_d    = S_GAP;
            next_d     = S_ACQ;
            load_val_o = CW'(1);
          end
        end
        S_DDS: if (expire_i) begin
          // two falls guarantee a full ADC period low after an unaligned end
          state_d = S_GAP; next_d = S_ADCRST;
          load_o = 1'b1; load_val_o = CW'(2);
        end
        S_ADCRST: if (expire_i) begin
          state_d = S_GAP; next_d = S_ACQ;
          load_o = 1'b1; load_val_o = CW'(1);
        end
        S_ACQ: if (expire_i) begin
          state_d = S_GAP;
          next_d  = start_sel_i ? S_WAIT_A : (stop_sel_i ? S_WAIT_B : S_DONE);
          load_o = 1'b1; load_val_o = CW'(1);
        end
        S_TRGA: if (expire_i) begin
          state_d = S_GAP;
          next_d  = stop_sel_i ? S_WAIT_B : S_DONE;
          load_o = 1'b1; load_val_o = CW'(1);
        end
        S_TRGB: if (expire_i) state_d = S_DONE;
        S_GAP: if (expire_i) begin
          state_d = next_q;
          if (next_q == S_ADCRST) begin
            load_o = 1'b1; load_val_o = CW'(P2_LEN);
          end else if (next_q == S_ACQ) begin
            load_o = 1'b1; load_val_o = CW'(ACQ_LEN);
          end
        end
        S_WAIT_A: if (start_ev_i) state_d = S_PEND_A;
        S_PEND_A: if (adc_fall_i) begin
          state_d = S_TRGA; load_o = 1'b1; load_val_o = CW'(TRIG_LEN);
        end
        S_WAIT_B: if (stop_ev_i) state_d = S_PEND_B;
        S_PEND_B: if (adc_fall_i) begin
          state_d = S_TRGB; load_o = 1'b1; load_val_o = CW'(TRIG_LEN);
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sync_pulse_seq.sv
module sync_pulse_seq
  import sync_seq_pkg::*;
#(
  parameter int P1_CYC      = 40,
  parameter int P2_LEN      = 11468800,
  parameter int ACQ_LEN     = 5,
  parameter int TRIG_LEN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adc_clk_i,
  input  logic       master_i,
  input  logic       arm_i,
  input  logic       sync_need_i,
  input  logic       start_sel_i,
  input  logic       stop_sel_i,
  input  logic       start_ev_i,
  input  logic       stop_ev_i,
  output logic       sync_o,
  output logic       busy_o,
  output logic [2:0] phase_o
);
  localparam int MAX_A = (P1_CYC > P2_LEN) ? P1_CYC : P2_LEN;
  localparam int MAX_B = (ACQ_LEN > TRIG_LEN) ? ACQ_LEN : TRIG_LEN;
  localparam int MAX_V = ((MAX_A > MAX_B) ? MAX_A : MAX_B) + 2;
  localparam int CW    = $clog2(MAX_V + 1);

  logic          adc_fall;
  logic          load, tick, expire;
  logic [CW-1:0] load_val;
  seq_state_e    state;

  adc_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adc_clk_i (adc_clk_i),
    .fall_o    (adc_fall)
  );

  phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .expire_o   (expire)
  );

  seq_fsm #(
    .P1_CYC(P1_CYC), .P2_LEN(P2_LEN), .ACQ_LEN(ACQ_LEN),
    .TRIG_LEN(TRIG_LEN), .CW(CW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (arm_i & master_i),
    .sync_need_i (sync_need_i),
    .start_sel_i (start_sel_i),
    .stop_sel_i  (stop_sel_i),
    .start_ev_i  (start_ev_i),
    .stop_ev_i   (stop_ev_i),
    .adc_fall_i  (adc_fall),
    .expire_i    (expire),
    .state_o     (state),
    .load_o      (load),
    .load_val_o  (load_val),
    .tick_o      (tick)
  );

  always_comb begin
    case (state)
      S_DDS, S_ADCRST, S_ACQ, S_TRGA, S_TRGB: sync_o = 1'b1;
      default:                                sync_o = 1'b0;
    endcase
  end

  assign busy_o  = (state != S_IDLE) && (state != S_DONE);
  assign phase_o = phase_code(state);
endmodule

// File: rtl/sync_pulse_seq_chk.sv
module sync_pulse_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arm_i,
  input logic       master_i,
  input logic       adc_fall,
  input logic       sync_o,
  input logic       busy_o,
  input logic [2:0] phase_o
);
  // R10
  abort_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arm_i && master_i) |=> (!sync_o && phase_o == 3'd0));

  // R5
  adc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_o) && phase_o != 3'd1) |-> $past(adc_fall));

  // R8
  acq_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_o) && phase_o == 3'd3) |-> $past(phase_o) == 3'd6);

  // R11
  done_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_o) == 3'd7 && phase_o != 3'd7) |-> phase_o == 3'd0);

  // R12
  busy_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (phase_o != 3'd0 && phase_o != 3'd7));

  // R12
  line_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (phase_o >= 3'd1 && phase_o <= 3'd5));
endmodule

bind sync_pulse_seq sync_pulse_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .arm_i    (arm_i),
  .master_i (master_i),
  .adc_fall (adc_fall),
  .sync_o   (sync_o),
  .busy_o   (busy_o),
  .phase_o  (phase_o)
);

// File: tb/sim_sync_pulse_seq.sv
`timescale 1ns/1ps
module sim_sync_pulse_seq;
  localparam int P1 = 6, P2 = 3, ACQ = 5, TRG = 2, D = 8;

  logic clk = 1'b0, rst_n = 1'b0, adc = 1'b1;
  logic master = 1'b0, arm = 1'b0, sneed = 1'b0, ssel = 1'b0, psel = 1'b0;
  logic sev = 1'b0, pev = 1'b0;
  logic sync_o, busy_o;
  logic [2:0] phase_o;

  int n_chk = 0, n_bad = 0, cyc = 0, np = 0, last_fall = 0;
  int rs[16], wd[16], ph[16], gp[16];
  bit prev = 1'b0;

  always #2.5 clk = ~clk;
  initial begin #1; forever #20 adc = ~adc; end

  sync_pulse_seq #(.P1_CYC(P1), .P2_LEN(P2), .ACQ_LEN(ACQ), .TRIG_LEN(TRG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .adc_clk_i(adc), .master_i(master),
    .arm_i(arm), .sync_need_i(sneed), .start_sel_i(ssel), .stop_sel_i(psel),
    .start_ev_i(sev), .stop_ev_i(pev), .sync_o(sync_o), .busy_o(busy_o),
    .phase_o(phase_o));

  // pulse recorder, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      if (sync_o && !prev) begin
        if (np < 16) begin rs[np] = cyc; ph[np] = phase_o; gp[np] = cyc - last_fall; end
        np++;
      end
      if (!sync_o && prev) begin
        if (np > 0 && np <= 16) wd[np-1] = cyc - rs[np-1];
        last_fall = cyc;
      end
      prev = sync_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit s, input bit p);
    @(negedge clk); sev = s; pev = p;
    @(negedge clk); sev = 1'b0; pev = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input bit sn, input bit ss, input bit sp);
    int base, en, k3;
    int ew[5], eph[5];
    np = 0; last_fall = cyc;
    sneed = sn; ssel = ss; psel = sp; master = 1'b1;
    @(negedge clk); arm = 1'b1;
    base = sn ? 2 : 0;
    en = 0;
    if (sn) begin
      ew[0] = P1; eph[0] = 1; ew[1] = P2 * D; eph[1] = 2; en = 2;
    end
    ew[en] = ACQ * D; eph[en] = 3; en++;
    if (ss) begin ew[en] = TRG * D; eph[en] = 4; en++; end
    if (sp) begin ew[en] = TRG * D; eph[en] = 5; en++; end
    // R9: strobes during the acquisition-start pulse are ignored
    while (!(np == base + 1 && sync_o)) @(negedge clk);
    strobe(1'b1, 1'b1);
    // R9: strobes in the gap right after it are ignored
    while (sync_o) @(negedge clk);
    strobe(1'b1, 1'b1);
    idle(3 * D);
    chk(phase_o == 3'd6 || phase_o == 3'd7, "R12 wait code", phase_o, 6);
    chk(busy_o == (phase_o == 3'd6), "R12 busy", busy_o, phase_o == 3'd6);
    // R7: stop strobe while a start is awaited is ignored; real stop otherwise
    strobe(1'b0, 1'b1);
    if (ss) begin
      idle(3 * D);
      strobe(1'b1, 1'b0);
      while (!(np == base + 2 && sync_o)) @(negedge clk);
      strobe(1'b0, 1'b1);                 // R9: during start-trigger pulse
      while (sync_o) @(negedge clk);
      idle(3 * D);
      strobe(1'b0, 1'b1);
    end
    idle(10 * D);
    chk(np == en, "R6/R7 pulse count", np, en);
    k3 = base;
    for (int k = 0; k < en && k < np; k++) begin
      chk(ph[k] == eph[k], "R8 order", ph[k], eph[k]);
      if (eph[k] == 1) chk(wd[k] == ew[k], "R3 width", wd[k], ew[k]);
      else if (eph[k] == 2) chk(wd[k] == ew[k], "R4 width", wd[k], ew[k]);
      else if (eph[k] == 3) chk(wd[k] == ew[k], "R5 width", wd[k], ew[k]);
      else if (eph[k] == 4) chk(wd[k] == ew[k], "R6 width", wd[k], ew[k]);
      else chk(wd[k] == ew[k], "R7 width", wd[k], ew[k]);
      if (k > 0) chk(gp[k] >= D, "R8 gap", gp[k], D);
      if (eph[k] > 1 && k != k3)
        chk((rs[k] - rs[k3]) % D == 0, "R5 align", (rs[k] - rs[k3]) % D, 0);
    end
    if (sn && np > 2) chk(gp[2] == D, "R8 exact gap", gp[2], D);
    chk(phase_o == 3'd7 && !busy_o && !sync_o, "R11 done", phase_o, 7);
    @(negedge clk); arm = 1'b0;
    @(negedge clk);
    chk(phase_o == 3'd0 && !busy_o, "R10 idle after disarm", phase_o, 0);
  endtask

  initial begin
    idle(4);
    chk(!sync_o && !busy_o && phase_o == 3'd0, "R1 reset", phase_o, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(!sync_o && !busy_o && phase_o == 3'd0, "R1 idle", phase_o, 0);

    for (int c = 0; c < 8; c++) run(c[2], c[1], c[0]);

    // R2: non-master board stays quiet
    np = 0; master = 1'b0; sneed = 1'b1; ssel = 1'b0; psel = 1'b0;
    @(negedge clk); arm = 1'b1;
    idle(12 * D);
    chk(np == 0, "R2 no pulses", np, 0);
    chk(phase_o == 3'd0 && !busy_o, "R2 idle", phase_o, 0);
    arm = 1'b0;

    // R10: abort during the reset pulse
    np = 0; master = 1'b1;
    @(negedge clk); arm = 1'b1;
    while (phase_o != 3'd2) @(negedge clk);
    chk(sync_o == 1'b1, "R4 reset pulse high", sync_o, 1);
    arm = 1'b0;
    @(negedge clk);
    chk(!sync_o && phase_o == 3'd0, "R10 abort", phase_o, 0);
    idle(6 * D);
    chk(np == 2 && !sync_o, "R10 no resume", np, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule